// File: doc/BRIEF.md
# Processor System Register File

This block holds the control and status registers of a 32-bit processor core, selected by a 5-bit index. A write port loads a register with a value that is filtered per register: some bits are forced to zero, some registers hold a fixed identity value, and one register takes the absolute value of what is written. A separate read port returns any register combinationally from the stored state. A debug flag on the write port allows the exception cause register to be loaded and stores the raw value into the absolute-value scratch register.

The block keeps the program status word. That word holds the arithmetic flags, the floating-point flags, the interrupt control bits and a 4-bit interrupt level. The block also keeps save registers for the program counter and status word, one pair for ordinary exceptions and one pair for fatal errors. It also keeps the exception cause register, an instruction-cache enable bit, an address-trap register and two scratch registers.

A return-from-exception strobe picks one save pair by the status word's fatal-nesting bit. It presents the saved program counter at once and loads the saved status word on the next clock edge.

Top module: `sysreg_file`

## Requirements
- R1: After reset every storable register reads zero: indexes 0, 1, 2, 3, 4, 5, 24, 25, 29 and 31.
- R2: The status word (index 5) and both saved status words (indexes 1 and 3) keep only the bits of mask 0x000FF3FF, and all other bits read zero. The bit layout is: Z bit 0, S 1, OV 2, CY 3, FPR 4, FUD 5, FOV 6, FZD 7, FIV 8, FRO 9, ID 12, AE 13, EP 14, NP 15, and the interrupt level in bits 19:16.
- R3: Writes to the saved exception PC (index 0), the saved fatal PC (index 2) and the address-trap register (index 25) clear bit 0.
- R4: Index 6 always reads 0x00005346, index 7 always reads 0x000000E0 and index 30 always reads 0x00000004. Writes to these indexes change nothing.
- R5: The cache-control register (index 24) stores only bit 1, which drives `icache_en`. All its other bits read zero.
- R6: The cause register (index 4) holds the fatal cause in bits 31:16 and the exception cause in bits 15:0. It changes only on a write with `wr_debug` set.
- R7: A normal write to index 31 stores the absolute value of a negative input (0x80000000 stays 0x80000000). A debug write stores the raw input.
- R8: Index 29 stores any written value unchanged.
- R9: Any index not listed above reads zero and ignores writes.
- R10: While `reti` is high, `resume_pc` shows the saved fatal PC if status bit 15 (NP) is 1, and the saved exception PC otherwise. At the next edge the status word loads the matching saved status word.
- R11: When `reti` and a write to index 5 fall in the same cycle, the restored status word wins.
- R12: `wr_stored` shows, in the same cycle as the write, the value the addressed register will hold after the edge, which is the value it will read back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_idx | input | 5 | Register index to write |
| wr_data | input | 32 | Value to write |
| wr_debug | input | 1 | Debug write flag |
| wr_stored | output | 32 | Value as stored after filtering |
| rd_idx | input | 5 | Register index to read |
| rd_data | output | 32 | Read value, combinational |
| reti | input | 1 | Return-from-exception strobe |
| resume_pc | output | 32 | PC to resume at on return |
| status_word | output | 32 | Current program status word |
| icache_en | output | 1 | Instruction-cache enable bit |

## Verification
The bench builds the block with its default parameters: a 32-bit data path, a 5-bit index and the default identity constants. With these, every index from 0 to 31 can be reached. That covers each filtering rule, the constant registers and the unused indexes that read zero. The exception cause register is written with and without the debug flag in sequence, so that both its hold and its load behaviour are seen. The return strobe is exercised with NP set and with NP clear, and also in the same cycle as a status-word write.

// File: rtl/sysreg_pkg.sv
package sysreg_pkg;

    localparam int SR_W  = 32;
    localparam int IDX_W = 5;

    // Index map (bit 15 of status selects the fatal save pair)
    localparam logic [IDX_W-1:0] IX_EPC   = 5'd0;
    localparam logic [IDX_W-1:0] IX_ESW   = 5'd1;
    localparam logic [IDX_W-1:0] IX_FPC   = 5'd2;
    localparam logic [IDX_W-1:0] IX_FSW   = 5'd3;
    localparam logic [IDX_W-1:0] IX_CAUSE = 5'd4;
    localparam logic [IDX_W-1:0] IX_STAT  = 5'd5;
    localparam logic [IDX_W-1:0] IX_ID    = 5'd6;
    localparam logic [IDX_W-1:0] IX_TASK  = 5'd7;
    localparam logic [IDX_W-1:0] IX_CACHE = 5'd24;
    localparam logic [IDX_W-1:0] IX_TRAP  = 5'd25;
    localparam logic [IDX_W-1:0] IX_SCR_A = 5'd29;
    localparam logic [IDX_W-1:0] IX_FIX30 = 5'd30;
    localparam logic [IDX_W-1:0] IX_SCR_B = 5'd31;

    localparam logic [SR_W-1:0] STAT_MASK  = 32'h000F_F3FF;
    localparam logic [SR_W-1:0] EVEN_MASK  = 32'hFFFF_FFFE;
    localparam int              CACHE_BIT  = 1;
    localparam int              NP_BIT     = 15;

    localparam logic [SR_W-1:0] DEF_ID    = 32'h0000_5346;
    localparam logic [SR_W-1:0] DEF_TASK  = 32'h0000_00E0;
    localparam logic [SR_W-1:0] DEF_FIX30 = 32'h0000_0004;

    typedef struct packed {
        logic [SR_W-1:0] epc;
        logic [SR_W-1:0] esw;
        logic [SR_W-1:0] fpc;
        logic [SR_W-1:0] fsw;
        logic [SR_W-1:0] cause;
        logic [SR_W-1:0] stat;
        logic            cache_en;
        logic [SR_W-1:0] trap;
        logic [SR_W-1:0] scr_a;
        logic [SR_W-1:0] scr_b;
    } sr_state_t;

endpackage

// File: rtl/sysreg_wfilter.sv
module sysreg_wfilter
    import sysreg_pkg::*;
#(
    parameter logic [SR_W-1:0] ID_VAL    = DEF_ID,
    parameter logic [SR_W-1:0] TASK_VAL  = DEF_TASK,
    parameter logic [SR_W-1:0] FIX30_VAL = DEF_FIX30
) (
    input  logic [IDX_W-1:0] idx,
    input  logic [SR_W-1:0]  data,
    input  logic             debug,
    input  logic [SR_W-1:0]  cause_cur,
    output logic [SR_W-1:0]  stored
);
    logic [SR_W-1:0] magnitude;

    always_comb begin
        magnitude = data[SR_W-1] ? (~data + 1'b1) : data;
    end

    always_comb begin
        unique case (idx)
            IX_EPC, IX_FPC, IX_TRAP: stored = data & EVEN_MASK;
            IX_ESW, IX_FSW, IX_STAT: stored = data & STAT_MASK;
            IX_CAUSE:                stored = debug ? data : cause_cur;
            IX_ID:                   stored = ID_VAL;
            IX_TASK:                 stored = TASK_VAL;
            IX_CACHE:                stored = data & (SR_W'(1) << CACHE_BIT);
            IX_SCR_A:                stored = data;
            IX_FIX30:                stored = FIX30_VAL;
            IX_SCR_B:                stored = debug ? data : magnitude;
            default:                 stored = '0;
        endcase
    end
endmodule

// File: rtl/sysreg_rdmux.sv
module sysreg_rdmux
    import sysreg_pkg::*;
#(
    parameter logic [SR_W-1:0] ID_VAL    = DEF_ID,
    parameter logic [SR_W-1:0] TASK_VAL  = DEF_TASK,
    parameter logic [SR_W-1:0] FIX30_VAL = DEF_FIX30
) (
    input  sr_state_t        st,
    input  logic [IDX_W-1:0] idx,
    output logic [SR_W-1:0]  data
);
    always_comb begin
        unique case (idx)
            IX_EPC:   data = st.epc;
            IX_ESW:   data = st.esw;
            IX_FPC:   data = st.fpc;
            IX_FSW:   data = st.fsw;
            IX_CAUSE: data = st.cause;
            IX_STAT:  data = st.stat;
            IX_ID:    data = ID_VAL;
            IX_TASK:  data = TASK_VAL;
            IX_CACHE: data = SR_W'(st.cache_en) << CACHE_BIT;
            IX_TRAP:  data = st.trap;
            IX_SCR_A: data = st.scr_a;
            IX_FIX30: data = FIX30_VAL;
            IX_SCR_B: data = st.scr_b;
            default:  data = '0;
        endcase
    end
endmodule

// File: rtl/sysreg_return.sv
module sysreg_return
    import sysreg_pkg::*;
(
    input  sr_state_t       st,
    output logic [SR_W-1:0] pc_out,
    output logic [SR_W-1:0] stat_out
);
    logic fatal_nest;

    always_comb begin
        fatal_nest = st.stat[NP_BIT];
        pc_out     = fatal_nest ? st.fpc : st.epc;
        stat_out   = fatal_nest ? st.fsw : st.esw;
    end
endmodule

// File: rtl/sysreg_file.sv
module sysreg_file
    import sysreg_pkg::*;
#(
    parameter logic [SR_W-1:0] ID_VAL    = DEF_ID,
    parameter logic [SR_W-1:0] TASK_VAL  = DEF_TASK,
    parameter logic [SR_W-1:0] FIX30_VAL = DEF_FIX30
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [SR_W-1:0]   wr_data,
    input  logic              wr_debug,
    output logic [SR_W-1:0]   wr_stored,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [SR_W-1:0]   rd_data,
    input  logic              reti,
    output logic [SR_W-1:0]   resume_pc,
    output logic [SR_W-1:0]   status_word,
    output logic              icache_en
);
    sr_state_t       st_d, st_q;
    logic [SR_W-1:0] stored_w;
    logic [SR_W-1:0] ret_stat;

    sysreg_wfilter #(
        .ID_VAL(ID_VAL), .TASK_VAL(TASK_VAL), .FIX30_VAL(FIX30_VAL)
    ) u_wf (
        .idx(wr_idx), .data(wr_data), .debug(wr_debug),
        .cause_cur(st_q.cause), .stored(stored_w)
    );

    sysreg_rdmux #(
        .ID_VAL(ID_VAL), .TASK_VAL(TASK_VAL), .FIX30_VAL(FIX30_VAL)
    ) u_rd (
        .st(st_q), .idx(rd_idx), .data(rd_data)
    );

    sysreg_return u_ret (
        .st(st_q), .pc_out(resume_pc), .stat_out(ret_stat)
    );

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            unique case (wr_idx)
                IX_EPC:   st_d.epc      = stored_w;
                IX_ESW:   st_d.esw      = stored_w;
                IX_FPC:   st_d.fpc      = stored_w;
                IX_FSW:   st_d.fsw      = stored_w;
                IX_CAUSE: st_d.cause    = stored_w;
                IX_STAT:  st_d.stat     = stored_w;
                IX_CACHE: st_d.cache_en = stored_w[CACHE_BIT];
                IX_TRAP:  st_d.trap     = stored_w;
                IX_SCR_A: st_d.scr_a    = stored_w;
                IX_SCR_B: st_d.scr_b    = stored_w;
                default:  ;
            endcase
        end
        if (reti) begin
            st_d.stat = ret_stat;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign wr_stored   = stored_w;
    assign status_word = st_q.stat;
    assign icache_en   = st_q.cache_en;
endmodule

// File: rtl/sysreg_file_chk.sv
module sysreg_file_chk
    import sysreg_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [IDX_W-1:0] wr_idx,
    input logic             wr_debug,
    input logic             reti,
    input logic [SR_W-1:0]  status_word,
    input logic             icache_en,
    input logic [IDX_W-1:0] rd_idx,
    input logic [SR_W-1:0]  rd_data,
    input logic [SR_W-1:0]  cause_val,
    input logic [SR_W-1:0]  epc_val,
    input logic [SR_W-1:0]  fpc_val,
    input logic [SR_W-1:0]  trap_val,
    input logic [SR_W-1:0]  esw_val,
    input logic [SR_W-1:0]  fsw_val
);
    AST_STAT_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (status_word & ~STAT_MASK) == '0); // R2
    AST_PC_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
        !epc_val[0] && !fpc_val[0] && !trap_val[0]); // R3
    AST_ID_CONST: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_idx == IX_ID) |-> (rd_data == DEF_ID)); // R4
    AST_CACHE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_idx == IX_CACHE) |=> $stable(icache_en)); // R5
    AST_CAUSE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_idx == IX_CAUSE && wr_debug) |=> $stable(cause_val)); // R6
    AST_RETURN_STAT: assert property (@(posedge clk) disable iff (!rst_n)
        reti |=> status_word == ($past(status_word[NP_BIT]) ? $past(fsw_val)
                                                            : $past(esw_val))); // R10
endmodule

bind sysreg_file sysreg_file_chk u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_debug(wr_debug), .reti(reti), .status_word(status_word),
    .icache_en(icache_en), .rd_idx(rd_idx), .rd_data(rd_data),
    .cause_val(st_q.cause), .epc_val(st_q.epc), .fpc_val(st_q.fpc),
    .trap_val(st_q.trap), .esw_val(st_q.esw), .fsw_val(st_q.fsw)
);

// File: tb/sysreg_file_tb.sv
module sysreg_file_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [4:0]  wr_idx = '0;
    logic [31:0] wr_data = '0;
    logic        wr_debug = 1'b0;
    logic [31:0] wr_stored;
    logic [4:0]  rd_idx = '0;
    logic [31:0] rd_data;
    logic        reti = 1'b0;
    logic [31:0] resume_pc;
    logic [31:0] status_word;
    logic        icache_en;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    sysreg_file dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_data(wr_data), .wr_debug(wr_debug), .wr_stored(wr_stored),
        .rd_idx(rd_idx), .rd_data(rd_data), .reti(reti),
        .resume_pc(resume_pc), .status_word(status_word), .icache_en(icache_en)
    );

    // {index, debug, data, expected stored / read-back}
    localparam int NV = 20;
    localparam logic [69:0] VEC [NV] = '{
        {5'd5,  1'b0, 32'hFFFF_FFFF, 32'h000F_F3FF},  // R2 status
        {5'd1,  1'b0, 32'hFFFF_FFFF, 32'h000F_F3FF},  // R2 saved exc status
        {5'd3,  1'b0, 32'h1234_5678, 32'h0004_5278},  // R2 saved fatal status
        {5'd0,  1'b0, 32'h0000_1235, 32'h0000_1234},  // R3
        {5'd2,  1'b0, 32'hFFFF_FFFF, 32'hFFFF_FFFE},  // R3
        {5'd25, 1'b0, 32'h8000_0001, 32'h8000_0000},  // R3
        {5'd24, 1'b0, 32'hFFFF_FFFF, 32'h0000_0002},  // R5
        {5'd6,  1'b0, 32'h0000_0000, 32'h0000_5346},  // R4
        {5'd7,  1'b1, 32'hFFFF_FFFF, 32'h0000_00E0},  // R4
        {5'd30, 1'b0, 32'h0000_0000, 32'h0000_0004},  // R4
        {5'd4,  1'b0, 32'hDEAD_BEEF, 32'h0000_0000},  // R6 held
        {5'd4,  1'b1, 32'hDEAD_BEEF, 32'hDEAD_BEEF},  // R6 debug load
        {5'd4,  1'b0, 32'h0000_0000, 32'hDEAD_BEEF},  // R6 held
        {5'd31, 1'b0, 32'hFFFF_FFFF, 32'h0000_0001},  // R7
        {5'd31, 1'b0, 32'h8000_0000, 32'h8000_0000},  // R7
        {5'd31, 1'b1, 32'hFFFF_FFF0, 32'hFFFF_FFF0},  // R7 debug raw
        {5'd29, 1'b0, 32'hCAFE_F00D, 32'hCAFE_F00D},  // R8
        {5'd10, 1'b0, 32'hFFFF_FFFF, 32'h0000_0000},  // R9
        {5'd31, 1'b0, 32'h7FFF_FFFF, 32'h7FFF_FFFF},  // R7
        {5'd5,  1'b0, 32'h0000_8001, 32'h0000_8001}   // R2 NP and Z
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [4:0] ix, input logic dbg, input logic [31:0] d,
                            input logic [31:0] exp, input string req);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = ix; wr_debug = dbg; wr_data = d;
        #1 check({req, " R12 stored"}, wr_stored, exp);
        @(posedge clk);
        #1 wr_en = 1'b0; wr_debug = 1'b0; rd_idx = ix;
        #1 check({req, " readback"}, rd_data, exp);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1 reset state
        for (int i = 0; i < 32; i++) begin
            logic [31:0] e;
            e = (i == 6) ? 32'h5346 : (i == 7) ? 32'hE0 : (i == 30) ? 32'h4 : 32'h0;
            rd_idx = 5'(i);
            #1 check("R1 reset", rd_data, e);
        end
        check("R1 icache_en", {31'b0, icache_en}, 32'h0);

        for (int v = 0; v < NV; v++) begin
            do_write(VEC[v][69:65], VEC[v][64], VEC[v][63:32], VEC[v][31:0], "vec");
        end
        check("R5 icache_en", {31'b0, icache_en}, 32'h1);
        check("R2 status port", status_word, 32'h0000_8001);

        // R10 with NP=1: fatal pair
        @(negedge clk);
        reti = 1'b1;
        #1 check("R10 resume fatal", resume_pc, 32'hFFFF_FFFE);
        @(posedge clk);
        #1 reti = 1'b0;
        check("R10 status from fatal save", status_word, 32'h0004_5278);

        // R10 with NP=0: exception pair
        @(negedge clk);
        reti = 1'b1;
        #1 check("R10 resume exc", resume_pc, 32'h0000_1234);
        @(posedge clk);
        #1 reti = 1'b0;
        check("R10 status from exc save", status_word, 32'h000F_F3FF);

        // R11: return wins over a same-cycle status write (NP now 1)
        @(negedge clk);
        reti = 1'b1; wr_en = 1'b1; wr_idx = 5'd5; wr_data = 32'h0;
        @(posedge clk);
        #1 reti = 1'b0; wr_en = 1'b0;
        check("R11 return over write", status_word, 32'h0004_5278);

        // R5 clearing the cache bit
        do_write(5'd24, 1'b0, 32'hFFFF_FFFD, 32'h0, "R5 clear");
        check("R5 icache_en off", {31'b0, icache_en}, 32'h0);

        // R1 reset again clears stored values
        @(negedge clk); rst_n = 1'b0;
        @(posedge clk); #1 rst_n = 1'b1; rd_idx = 5'd29;
        #1 check("R1 second reset", rd_data, 32'h0);
        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 20000 && !done; c++) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected done");
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule